// File: doc/BRIEF.md
# Cache Tag Store with Equality Comparator

This block keeps one small tag per cache line and answers, on every clock, whether the tag stored at the presented index equals the tag on the data input. It holds 4096 words of 4 bits. Three active-low strobes choose among four modes. With all strobes high, the block compares. With the output strobe low it reads. With the write strobe low it writes. With the clear strobe low it empties the whole store in a single cycle. Wider tags are built by placing several copies side by side and ANDing their match flags outside the block.

The block is fully synchronous. A write commits on the rising edge at which the write strobe is sampled low. The match flag, the read word and the output-drive flag are all registered, so each reflects the inputs of the edge just taken. The comparator stays live in every mode. During a read it compares the stored word with itself. During an accepted write it compares the word being written with itself. In both cases the flag reads high. Clear is built from a per-entry valid bitmap that drops to zero in one cycle, and an entry that is not valid reads as zero. After clear is released, a short guard window rejects writes, so a write is never accepted right after a clear.

Top module: `tag_cmp_ram`

## Requirements
- R1: The store holds 2^AW words of DW bits (4096 x 4 by default), selected by an AW-bit index. A word written at an index is returned by a later read of that index, and other indices are not changed.
- R2: Match mode is all three strobes high. One cycle after the edge, `match` is 1 if the stored word equals `din` in every bit, and 0 otherwise.
- R3: Read mode is `we_n`=1, `clr_n`=1, `oe_n`=0. One cycle after the edge, `dout` holds the word stored at `addr` and `dout_en` is 1.
- R4: Write mode is `we_n`=0 with `clr_n`=1. When it is accepted, `din` is stored at `addr` on that edge. `dout_en` is 0 in the following cycle whatever the value of `oe_n`.
- R5: In the cycle after a read or an accepted write, `match` is 1.
- R6: When `clr_n` is sampled 0, every entry reads as zero from the next cycle on, whatever `we_n` and `oe_n` are.
- R7: A write strobe in any of the first GUARD cycles (default 1) after `clr_n` returns high is ignored, and the addressed entry keeps its value.
- R8: During and after reset, `match`, `dout_en` and `dout` are 0 and every entry reads as zero.
- R9: In match mode, `dout_en` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Index of the tag entry |
| din | input | DW | Write data and compare data |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| clr_n | input | 1 | Active-low clear of the whole store |
| dout | output | DW | Registered read word |
| dout_en | output | 1 | High when `dout` should drive the shared data lines |
| match | output | 1 | Registered equality flag |

## Verification
A wrong valid bit or a corrupted stored word appears at the ports exactly one cycle after the index is next presented. It shows as a wrong `dout` in read mode, or as a flipped `match` in compare mode. Sweeping every index with an index-derived pattern catches any aliasing in the addressing. Sweeping all sixteen compare values over a spread of indices exposes a comparator bit that is stuck or inverted. A guard or clear fault shows one cycle later: a read of the index touched right after a clear returns a nonzero word.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

  typedef enum logic [1:0] {
    M_MATCH = 2'd0,
    M_READ  = 2'd1,
    M_WRITE = 2'd2,
    M_CLEAR = 2'd3
  } mode_e;

  // Clear overrides write; write overrides the output strobe.
  function automatic mode_e decode_mode(input logic we_n, input logic oe_n,
                                        input logic clr_n);
    mode_e m;
    if (!clr_n)     m = M_CLEAR;
    else if (!we_n) m = M_WRITE;
    else if (!oe_n) m = M_READ;
    else            m = M_MATCH;
    return m;
  endfunction

  // Drive the data lines only when the output strobe is low and no write is in progress.
  function automatic logic drives_bus(input mode_e m, input logic oe_n);
    return (m != M_WRITE) && !oe_n;
  endfunction

endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
  import tagram_pkg::*;
#(
  parameter int GUARD = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_n,
  input  logic  oe_n,
  input  logic  clr_n,
  output mode_e mode,
  output logic  wr_fire,
  output logic  clr_fire,
  output logic  drive_nxt
);
  localparam int GW = $clog2(GUARD + 1);

  logic [GW-1:0] guard_cnt;
  logic          guard_open;

  assign mode       = decode_mode(we_n, oe_n, clr_n);
  assign guard_open = (guard_cnt == '0);
  assign clr_fire   = (mode == M_CLEAR);
  assign wr_fire    = (mode == M_WRITE) && guard_open;
  assign drive_nxt  = drives_bus(mode, oe_n);

  // The counter is reloaded while clear is held low and counts down once clear is released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      guard_cnt <= '0;
    else if (clr_fire)
      guard_cnt <= GW'(GUARD);
    else if (!guard_open)
      guard_cnt <= guard_cnt - 1'b1;
  end
endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
  parameter int AW = 12,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem   [DEPTH];
  logic [DEPTH-1:0] valid;

  // An entry whose valid bit is clear reads as zero.
  assign rdata = valid[addr] ? mem[addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid <= '0;
    else if (clr_all)
      valid <= '0;
    else if (wr_en)
      valid[addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[addr] <= wdata;
  end
endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          eq
);
  logic [DW-1:0] bit_eq;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign bit_eq[i] = ~(a[i] ^ b[i]);
  end

  assign eq = &bit_eq;
endmodule

// File: rtl/tag_cmp_ram.sv
module tag_cmp_ram
  import tagram_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 4,
  parameter int GUARD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          clr_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          match
);
  mode_e         mode;
  logic          wr_fire;
  logic          clr_fire;
  logic          drive_nxt;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] cmp_a;
  logic [DW-1:0] cmp_b;
  logic          cmp_eq;

  tagram_ctrl #(.GUARD(GUARD)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .clr_n    (clr_n),
    .mode     (mode),
    .wr_fire  (wr_fire),
    .clr_fire (clr_fire),
    .drive_nxt(drive_nxt)
  );

  tagram_array #(.AW(AW), .DW(DW)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_all(clr_fire),
    .wr_en  (wr_fire),
    .addr   (addr),
    .wdata  (din),
    .rdata  (rd_word)
  );

  // The comparator stays live in every mode.
  // During a read it sees the word on the data lines, which is the stored word.
  // During an accepted write it sees the word being written.
  always_comb begin
    cmp_a = wr_fire ? din : rd_word;
    cmp_b = (mode == M_READ) ? rd_word : din;
  end

  tagram_cmp #(.DW(DW)) u_cmp (
    .a (cmp_a),
    .b (cmp_b),
    .eq(cmp_eq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match   <= 1'b0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      match   <= cmp_eq;
      dout    <= rd_word;
      dout_en <= drive_nxt;
    end
  end
endmodule

// File: rtl/tagram_chk.sv
module tagram_chk #(
  parameter int AW = 12,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          clr_n,
  input logic [DW-1:0] din,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          match,
  input logic [DW-1:0] rd_word,
  input logic          wr_fire
);
  a_r2_match_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n && clr_n && rd_word == din) |=> match);

  a_r2_match_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n && clr_n && rd_word != din) |=> !match);

  a_r3_read_word: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && clr_n && !oe_n) |=> (dout_en && dout == $past(rd_word)));

  a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && clr_n) |=> !dout_en);

  a_r5_write_match: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> match);

  a_r5_read_match: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && clr_n && !oe_n) |=> match);

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (rd_word == '0));

  a_r7_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_n) |-> !wr_fire);

  a_r9_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n && clr_n) |=> !dout_en);
endmodule

bind tag_cmp_ram tagram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .clr_n  (clr_n),
  .din    (din),
  .dout   (dout),
  .dout_en(dout_en),
  .match  (match),
  .rd_word(rd_word),
  .wr_fire(wr_fire)
);

// File: tb/sim_tag_cmp_ram.sv
module sim_tag_cmp_ram;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 12;
  localparam int DW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int LIMIT = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          match;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  tag_cmp_ram #(.AW(AW), .DW(DW), .GUARD(1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
    .dout(dout), .dout_en(dout_en), .match(match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Test pattern: the XOR of the three nibbles of the index.
  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a ^ (a >> 4) ^ (a >> 8)) & 15);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply the inputs and take one edge, then sample just after it.
  task automatic step(input int a, input int d, input bit w, input bit o, input bit c);
    addr = AW'(a); din = DW'(d); we_n = w; oe_n = o; clr_n = c;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > LIMIT) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs held low during reset
    chk(match == 0 && dout_en == 0 && dout == 0, "R8 reset outputs",
        {match, dout_en, dout}, 0);
    rst_n = 1'b1;
    // R8: entries read zero after reset
    step(0, 0, 1, 0, 1);
    chk(dout_en && dout == 0, "R8 entry 0 empty", dout, 0);
    step(DEPTH-1, 0, 1, 0, 1);
    chk(dout_en && dout == 0, "R8 last entry empty", dout, 0);
    // R9: match mode does not drive
    step(DEPTH-1, 0, 1, 1, 1);
    chk(!dout_en, "R9 no drive in match mode", dout_en, 0);
    chk(match, "R2 empty entry matches zero", match, 1);

    // R1/R4/R5: write every index. Odd indices also pull oe_n low.
    for (int a = 0; a < DEPTH; a++) begin
      step(a, pat(a), 0, a[0] ? 1'b0 : 1'b1, 1);
      chk(!dout_en, "R4 write does not drive", dout_en, 0);
      chk(match, "R5 match after write", match, 1);
    end

    // R1/R3/R5: read every index
    for (int a = 0; a < DEPTH; a++) begin
      step(a, 0, 1, 0, 1);
      chk(dout_en && dout == pat(a), "R1 R3 read back", dout, pat(a));
      chk(match, "R5 match during read", match, 1);
    end

    // R2: all compare values over a spread of indices
    for (int i = 0; i < 256; i++) begin
      for (int d = 0; d < 16; d++) begin
        int a = i * 16 + 3;
        step(a, d, 1, 1, 1);
        chk(match == (d == pat(a)), "R2 compare", match, d == pat(a));
      end
    end

    // R6: clear with the write strobe and output strobe low at the same time
    step(5, 9, 0, 0, 0);
    // R7: a write right after clear is ignored
    step(5, 9, 0, 1, 1);
    step(5, 0, 1, 0, 1);
    chk(dout_en && dout == 0, "R6 R7 index 5 empty after clear", dout, 0);
    step(100, 0, 1, 0, 1);
    chk(dout == 0, "R6 index 100 empty after clear", dout, 0);
    step(DEPTH-1, 0, 1, 0, 1);
    chk(dout == 0, "R6 last index empty after clear", dout, 0);
    step(7, 0, 1, 1, 1);
    chk(match, "R6 cleared entry matches zero", match, 1);
    step(7, 3, 1, 1, 1);
    chk(!match, "R2 cleared entry misses 3", match, 0);
    // R1/R7: once the guard window has passed, writes are accepted again
    step(5, 9, 0, 1, 1);
    step(5, 0, 1, 0, 1);
    chk(dout == 9, "R7 write accepted after guard", dout, 9);
    step(6, 0, 1, 0, 1);
    chk(dout == 0, "R1 neighbour untouched", dout, 0);
    step(5, 9, 1, 1, 1);
    chk(match, "R2 hit on rewritten entry", match, 1);
    step(5, 8, 1, 1, 1);
    chk(!match, "R2 single-bit miss", match, 0);

    finish_run();
  end
endmodule